// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs register read and write transactions toward an Ethernet PHY over the two-wire management bus. It drives a management clock and a bidirectional data line. The data line is presented as three separate signals: a data output, an output enable, and a data input. A host issues a single-cycle request that carries a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then sequences the whole frame by itself and returns a one-cycle completion pulse, the 16-bit read result and an error flag.

Every frame is exactly 64 management clock periods long:

| Bit periods | Phase |
|---|---|
| 0–31 | Preamble, line driven high |
| 32–33 | Start code |
| 34–35 | Opcode |
| 36–40 | PHY address |
| 41–45 | Register address |
| 46–47 | Turnaround |
| 48–63 | Data |

On reads, the block releases the line for the turnaround and data periods. It treats a high level in the second turnaround period as a missing PHY. In that case the data result is forced to zero, but all sixteen data periods are still clocked out. The management clock period is 2×DIV system clocks, where DIV is a parameter of at least 1.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset the block is idle with `busy_o`=0, `done_o`=0, `mdc_o`=0, `mdo_o`=1, `mdo_en_o`=1, `rdata_o`=0 and `err_o`=0. A reset in mid-frame returns it to this state.
- R2: A request on `req_i` is taken only while `busy_o` is 0. `busy_o` rises on the cycle after acceptance and stays high for exactly 128×DIV+1 cycles. Requests made while busy are ignored and start no later frame.
- R3: During a frame `mdc_o` runs with a period of 2×DIV system clocks. Each period has a low half of DIV clocks followed by a high half of DIV clocks. Between frames `mdc_o` stays low.
- R4: Bit periods 0 to 31 carry a preamble of 32 ones with `mdo_en_o`=1.
- R5: Bit periods 32 to 45 carry, MSB first, the start code 01, the opcode (10 for read, 01 for write), the PHY address and the register address.
- R6: A write sends the turnaround pattern 10 in periods 46–47, then the 16 data bits MSB first in periods 48–63. `mdo_en_o` stays 1 for the whole write and while idle.
- R7: A read sets `mdo_en_o` to 0 for bit periods 46 to 63 and returns it to 1 when the frame ends. The enable changes only while `mdc_o` is low, so it adds no clock edge.
- R8: On a read, `mdi_i` is sampled in the last system clock before the rising edge of bit period 47. A 1 there sets `err_o`. Writes always finish with `err_o`=0.
- R9: On a read, `mdi_i` is sampled just before the rising edge of periods 48 to 63. The samples are assembled MSB first into `rdata_o`.
- R10: When `err_o` is 1, `rdata_o` is 0 whatever `mdi_i` carried. The frame still has all 64 clock periods.
- R11: `mdo_o` and `mdo_en_o` never change while `mdc_o` is high, so data is stable across each rising edge.
- R12: `done_o` is a one-cycle pulse in the last busy cycle. `rdata_o` and `err_o` hold their values until the next accepted request, which clears them; a write therefore ends with `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Transaction request, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result (zero on error or write) |
| err_o | output | 1 | No PHY answered the read |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Data line output value |
| mdo_en_o | output | 1 | Data line output enable |
| mdi_i | input | 1 | Data line input |

## Verification
The bound checker watches four rules on every cycle:
- the clock stays low while idle, and every high half lasts DIV clocks;
- the line is never released during a write or while idle, and never changes direction or value while the clock is high;
- an error completion always carries zero data;
- a done pulse is always followed by idle.

Only the bench's scenarios can show the serial content of each frame against the host fields, the busy duration, and the error and data sampling positions. These depend on a PHY model that answers in specific bit periods. The bench also covers the MSB-first capture order, the masking of data the PHY still drives after signalling absence, requests ignored while busy, and a mid-frame reset.

// File: rtl/mdio_pkg.sv
// Package: shared constants, frame layout and sequencer state for the
// management frame master. Assumes a fixed 64-period frame layout.
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int ADDR_W     = 5;
    localparam int CODE_W     = 2;
    localparam int HDR_BITS   = 2 * CODE_W + 2 * ADDR_W;
    localparam int TA_BITS    = 2;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DATA_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [IDX_W-1:0] REL_POS  = IDX_W'(PRE_BITS + HDR_BITS);
    localparam logic [IDX_W-1:0] ERR_POS  = IDX_W'(PRE_BITS + HDR_BITS + 1);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_BITS - 1);

    localparam logic [CODE_W-1:0] SOF_CODE = 2'b01;
    localparam logic [CODE_W-1:0] OP_RD    = 2'b10;
    localparam logic [CODE_W-1:0] OP_WR    = 2'b01;
    localparam logic [CODE_W-1:0] TA_WR    = 2'b10;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_t;

    // Assemble the serial image of a frame, first bit at the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic                 wr,
        input logic [ADDR_W-1:0]    phy,
        input logic [ADDR_W-1:0]    rg,
        input logic [DATA_BITS-1:0] wd
    );
        logic [TA_BITS+DATA_BITS-1:0] tail;
        tail = wr ? {TA_WR, wd} : {(TA_BITS + DATA_BITS){1'b1}};
        return {{PRE_BITS{1'b1}}, SOF_CODE, (wr ? OP_WR : OP_RD), phy, rg, tail};
    endfunction
endpackage

// File: rtl/mdio_half_timer.sv
// Half-period timer: pulses half_end_o on the last system clock of each
// DIV-clock half period while run_i is high. Assumes DIV >= 1.
module mdio_half_timer #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic half_end_o
);
    generate
        if (DIV <= 1) begin : g_direct
            wire tie_unused = clk ^ rst_n;
            assign half_end_o = run_i;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            // Count system clocks within the current half period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) begin
                    cnt_q <= '0;
                end else if (cnt_q == CNT_LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign half_end_o = run_i && (cnt_q == CNT_LAST);
        end
    endgenerate
endmodule

// File: rtl/mdio_rx_capture.sv
// Read capture: latches the presence sample and shifts in data bits MSB
// first, forcing zeros once absence was seen. Cleared on each accepted
// request; otherwise holds its result.
module mdio_rx_capture
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 sample_i,
    input  logic                 err_slot_i,
    input  logic                 mdi_i,
    output logic [DATA_BITS-1:0] rdata_o,
    output logic                 err_o
);
    logic [DATA_BITS-1:0] shift_q;
    logic                 err_q;

    // Capture the presence bit and the data bits on sample strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            shift_q <= '0;
            err_q   <= 1'b0;
        end else if (sample_i) begin
            if (err_slot_i) begin
                err_q <= mdi_i;
            end else begin
                shift_q <= {shift_q[DATA_BITS-2:0], mdi_i & ~err_q};
            end
        end
    end

    assign rdata_o = shift_q;
    assign err_o   = err_q;
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: accepts a request while idle, then walks 64 bit periods,
// toggling the management clock on half-period ticks. The frame image is
// held in a shift register whose MSB is the current bit. It decides line
// direction and issues sample strobes for the capture unit.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    phy_addr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_BITS-1:0] wdata_i,
    input  logic                 half_end_i,
    output logic                 run_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 start_o,
    output logic                 mdc_o,
    output logic                 mdo_o,
    output logic                 mdo_en_o,
    output logic                 sample_o,
    output logic                 err_slot_o
);
    seq_state_t              state_q;
    logic [IDX_W-1:0]        bit_q;
    logic                    mdc_q;
    logic                    rd_q;
    logic [FRAME_BITS-1:0]   tx_q;
    logic                    accept;
    logic                    running;

    assign accept  = (state_q == ST_IDLE) && req_i;
    assign running = (state_q == ST_RUN);

    // Advance the frame: clock halves, bit index and transmit image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            mdc_q   <= 1'b0;
            rd_q    <= 1'b0;
            tx_q    <= '1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        bit_q   <= '0;
                        mdc_q   <= 1'b0;
                        rd_q    <= ~wr_i;
                        tx_q    <= build_frame(wr_i, phy_addr_i, reg_addr_i, wdata_i);
                    end
                end
                ST_RUN: begin
                    if (half_end_i) begin
                        if (!mdc_q) begin
                            mdc_q <= 1'b1;
                        end else begin
                            mdc_q <= 1'b0;
                            if (bit_q == LAST_POS) begin
                                state_q <= ST_DONE;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                                tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b1};
                            end
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the bus pins and the capture strobes from the frame state.
    always_comb begin
        run_o      = running;
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE);
        start_o    = accept;
        mdc_o      = mdc_q;
        mdo_o      = running ? tx_q[FRAME_BITS-1] : 1'b1;
        mdo_en_o   = !(running && rd_q && (bit_q >= REL_POS));
        sample_o   = running && half_end_i && !mdc_q && rd_q && (bit_q >= ERR_POS);
        err_slot_o = (bit_q == ERR_POS);
    end
endmodule

// File: rtl/mdio_frame_master.sv
// Top: management frame master. Ties the half-period timer, the frame
// sequencer and the read capture together. DIV sets the half period in
// system clocks and must be at least 1.
module mdio_frame_master #(
    parameter int DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        wr_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        err_o,
    output logic        mdc_o,
    output logic        mdo_o,
    output logic        mdo_en_o,
    input  logic        mdi_i
);
    logic half_end;
    logic run;
    logic start;
    logic sample;
    logic err_slot;

    mdio_half_timer #(.DIV(DIV)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .half_end_o (half_end)
    );

    mdio_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .wr_i       (wr_i),
        .phy_addr_i (phy_addr_i),
        .reg_addr_i (reg_addr_i),
        .wdata_i    (wdata_i),
        .half_end_i (half_end),
        .run_o      (run),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .start_o    (start),
        .mdc_o      (mdc_o),
        .mdo_o      (mdo_o),
        .mdo_en_o   (mdo_en_o),
        .sample_o   (sample),
        .err_slot_o (err_slot)
    );

    mdio_rx_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start),
        .sample_i   (sample),
        .err_slot_i (err_slot),
        .mdi_i      (mdi_i),
        .rdata_o    (rdata_o),
        .err_o      (err_o)
    );
endmodule

// File: rtl/mdio_frame_master_chk.sv
// Checker bound to the frame master: protocol rules that hold every cycle.
// Tracks the opcode of the accepted request and the length of clock-high runs.
module mdio_frame_master_chk #(
    parameter int DIV = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic        wr_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] rdata_o,
    input logic        err_o,
    input logic        mdc_o,
    input logic        mdo_o,
    input logic        mdo_en_o
);
    localparam int RW = $clog2(DIV + 2) + 1;
    logic          chk_wr;
    logic          mdc_d;
    logic [RW-1:0] high_len;

    // Remember whether the frame in flight is a write.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_wr <= 1'b0;
        else if (req_i && !busy_o) chk_wr <= wr_i;
    end

    // Count consecutive cycles of a high management clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_d    <= 1'b0;
            high_len <= '0;
        end else begin
            mdc_d <= mdc_o;
            if (!mdc_o || !mdc_d) high_len <= RW'(1);
            else high_len <= high_len + 1'b1;
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> busy_o);                                   // R2
    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mdc_o);                                              // R3
    AST_HIGH_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_d && !mdc_o) |-> (high_len == RW'(DIV)));                    // R3
    AST_IDLE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> mdo_en_o);                                            // R6
    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && chk_wr) |-> mdo_en_o);                                 // R6
    AST_DIR_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mdo_en_o != $past(mdo_en_o)) |-> !mdc_o);                        // R7
    AST_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && chk_wr) |-> !err_o);                                   // R8
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (rdata_o == 16'h0000));                     // R10
    AST_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdo_o) && $stable(mdo_en_o))); // R11
    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));                                 // R12
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.DIV(DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .wr_i     (wr_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rdata_o  (rdata_o),
    .err_o    (err_o),
    .mdc_o    (mdc_o),
    .mdo_o    (mdo_o),
    .mdo_en_o (mdo_en_o)
);

// File: tb/sim_mdio_frame_master.sv
`timescale 1ns/1ps
module sim_mdio_frame_master;
    localparam int TB_DIV = 3;
    localparam int BUSY_LEN = 128 * TB_DIV + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  pa = '0;
    logic [4:0]  ra = '0;
    logic [15:0] wd = '0;
    logic        busy, done, err, mdc, mdo, mdo_en;
    logic [15:0] rdata;
    logic        mdi = 1'b1;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mdio_frame_master #(.DIV(TB_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr),
        .phy_addr_i(pa), .reg_addr_i(ra), .wdata_i(wd),
        .busy_o(busy), .done_o(done), .rdata_o(rdata), .err_o(err),
        .mdc_o(mdc), .mdo_o(mdo), .mdo_en_o(mdo_en), .mdi_i(mdi)
    );

    // Compare one value and report on mismatch.
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Bus monitor and PHY model.
    int          clk_cnt = 0;
    int          rcnt = 0;
    int          last_rise = 0;
    int          bad_period = 0;
    int          bad_stable = 0;
    logic [63:0] cap_mdo = '0;
    logic [63:0] cap_oe = '0;
    logic        mon_rd = 1'b0;
    logic        phy_here = 1'b1;
    logic [15:0] phy_word = '0;
    logic        prev_mdc = 1'b0, prev_mdo = 1'b1, prev_oe = 1'b1;

    always @(posedge clk) clk_cnt++;

    always @(posedge mdc) begin
        if (rcnt < 64) begin
            cap_mdo[63-rcnt] = mdo;
            cap_oe[63-rcnt]  = mdo_en;
        end
        if (rcnt > 0 && (clk_cnt - last_rise) != 2 * TB_DIV) bad_period++;
        last_rise = clk_cnt;
        if (mon_rd) begin
            if (rcnt + 1 == 47) mdi <= phy_here ? 1'b0 : 1'b1;
            else if (rcnt + 1 >= 48 && rcnt + 1 <= 63) mdi <= phy_word[63-(rcnt+1)];
            else mdi <= 1'b1;
        end
        rcnt++;
    end

    always @(negedge clk) begin
        if (rst_n && prev_mdc && mdc && (mdo !== prev_mdo || mdo_en !== prev_oe)) bad_stable++;
        prev_mdc = mdc; prev_mdo = mdo; prev_oe = mdo_en;
    end

    // Run one frame and check it; poke issues an extra request while busy.
    task automatic run_frame(input string tag, input logic w, input logic [4:0] p,
                             input logic [4:0] r, input logic [15:0] d,
                             input logic here, input logic poke);
        int busy_n, done_n, wdog;
        logic [15:0] got_rd, exp_rd;
        logic got_err, exp_err;
        logic [63:0] exp_img, oe_mask;
        @(negedge clk);
        rcnt = 0; bad_period = 0; bad_stable = 0; cap_mdo = '0; cap_oe = '0;
        mon_rd = ~w; phy_word = d; phy_here = here; mdi = 1'b1;
        req = 1'b1; wr = w; pa = p; ra = r; wd = d;
        @(negedge clk);
        req = 1'b0;
        busy_n = 0; done_n = 0; wdog = 0; got_rd = '1; got_err = 1'bx;
        while (busy && wdog < 20000) begin
            busy_n++;
            if (done) begin
                done_n++;
                got_rd = rdata;
                got_err = err;
            end
            if (poke && wdog == 50) begin
                req = 1'b1; wr = ~w; pa = ~p; ra = ~r; wd = ~d;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
            wdog++;
        end
        req = 1'b0;
        exp_err = ~w & ~here;
        exp_rd  = (w || !here) ? 16'h0000 : d;
        exp_img = {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, 18'h0};
        if (w) exp_img[17:0] = {2'b10, d};
        oe_mask = w ? '1 : {46'h3FFF_FFFF_FFFF, 18'h0};
        chk({tag, " R2 busy length"}, 64'(busy_n), 64'(BUSY_LEN));
        chk({tag, " R12 one done pulse"}, 64'(done_n), 64'd1);
        chk({tag, " R3 clock period"}, 64'(bad_period), 64'd0);
        chk({tag, " R10 all 64 periods"}, 64'(rcnt), 64'd64);
        chk({tag, " R4 preamble"}, {32'h0, cap_mdo[63:32]}, {32'h0, 32'hFFFF_FFFF});
        chk({tag, " R5 header"}, 64'(cap_mdo[31:18]), 64'(exp_img[31:18]));
        if (w) chk({tag, " R6 ta+data"}, 64'(cap_mdo[17:0]), 64'(exp_img[17:0]));
        chk({tag, " R7 direction"}, cap_oe, oe_mask);
        chk({tag, " R8 err"}, 64'(got_err), 64'(exp_err));
        chk({tag, " R9 R10 rdata"}, 64'(got_rd), 64'(exp_rd));
        chk({tag, " R11 stable while high"}, 64'(bad_stable), 64'd0);
        chk({tag, " R6 R7 line driven after"}, 64'(mdo_en), 64'd1);
        repeat (3) @(negedge clk);
        chk({tag, " R12 result held"}, {47'h0, err, rdata}, {47'h0, exp_err, exp_rd});
        chk({tag, " R2 no extra frame"}, {62'h0, busy, mdc}, 64'd0);
    endtask

    // Stimulus table: {wr, phy, reg, data, phy_present}.
    localparam int NV = 6;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 5'h01, 5'h00, 16'hA5C3, 1'b1},
        {1'b0, 5'h03, 5'h02, 16'h1234, 1'b1},
        {1'b0, 5'h05, 5'h01, 16'hBEEF, 1'b0},
        {1'b1, 5'h1F, 5'h1F, 16'h0001, 1'b1},
        {1'b0, 5'h10, 5'h11, 16'h8001, 1'b1},
        {1'b0, 5'h0A, 5'h15, 16'hFFFF, 1'b1}
    };

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 reset state", {50'h0, busy, done, mdc, mdo, mdo_en, err, rdata[7:0]},
            {50'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {60'h0, busy, mdc, mdo_en, |rdata}, {60'h0, 4'b0010});

        for (int i = 0; i < NV; i++) begin
            run_frame($sformatf("vec%0d", i), VEC[i][27], VEC[i][26:22], VEC[i][21:17],
                      VEC[i][16:1], VEC[i][0], 1'b0);
        end

        // R2: a request while busy is ignored
        run_frame("poke", 1'b0, 5'h07, 5'h09, 16'h5A5A, 1'b1, 1'b1);

        // R1: reset in mid-frame
        @(negedge clk);
        req = 1'b1; wr = 1'b1; pa = 5'h02; ra = 5'h03; wd = 16'h0F0F;
        @(negedge clk);
        req = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-frame reset", {59'h0, busy, done, mdc, mdo, mdo_en}, {59'h0, 5'b00011});
        rst_n = 1'b1;
        mon_rd = 1'b0;
        run_frame("after-reset", 1'b0, 5'h11, 5'h04, 16'hC3A5, 1'b1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule